// File: doc/BRIEF.md
# Link Power-Down and Status Controller

This block holds the power control and status word of a serial-bus link layer. It decides when the link enters a low-power mode and drives the link-power-status line toward the physical-layer device. While that line toggles, the physical-layer device keeps supplying the link clock. When the line is held low, the physical-layer device is told to stop that clock. Power-down can be requested in two ways: by a software bit in the word, or by a hardware pin that overrides the software bit. While the link is powered down, only this word stays reachable. A gate output tells the other registers of the link that they are closed.

The same word also carries four sticky link/PHY event flags: PHY-link initialized, link-on active, PHY clock active and PHY clock inactive. Each flag has its own enable bit. A flag whose enable is clear is plain readable status. A flag whose enable is set also drives the interrupt output. A one-cycle request from elsewhere in the link can reset the link/PHY interface. That request drops the status line for a fixed number of cycles, and the status bit shows the drop. A single-word register port with a combinational read serves host access.

Top module: `lnkpwr_ctrl`

## Requirements
- R1: After reset the word reads 0x00000000, the interrupt and the status line are low, and the other registers are open. The status line stays inactive for RST_HOLD cycles after reset.
- R2: Writing 1 to bit 31 (software power-down) makes the status line inactive and holds `lps_out` low. Writing 0 to bit 31 makes the line active again.
- R3: While `pd_pin` is high, bit 31 is forced to 1 and the link is powered down. Software writes of 0 to bit 31 are ignored while the pin is high. After the pin drops, bit 31 stays 1 until software clears it.
- R4: `regs_access_en` is low exactly while the link is powered down. The control word stays readable and writable during power-down.
- R5: Bit 30 is read-only and is 1 exactly while the status line is active. While active, `lps_out` toggles once every LPS_DIV host cycles.
- R6: A one-cycle `rpl_req` makes the status line inactive for RST_HOLD cycles, and bit 30 reads 0 during that window.
- R7: The four flags sit in bits 3 (PHY-link initialized), 2 (link-on active), 1 (clock active) and 0 (clock inactive). The matching enables sit in bits 19, 18, 17 and 16. `irq` is the OR of each flag ANDed with its enable. With all enables clear, flags are status only.
- R8: Bit 1 sets on a rising edge of `phy_clk_present` and bit 0 sets on a falling edge. Both edges are seen after a two-stage synchronizer, so the flag shows on the third edge after the input changes.
- R9: Flags are sticky. Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. A set event in the same cycle as a clear wins.
- R10: Bits 29..20 and 15..4 read 0 and ignore writes. Reads of any other address return 0, and writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_pin | input | 1 | Hardware power-down request, synchronous to clk |
| phy_clk_present | input | 1 | Asynchronous indication that the PHY clock runs |
| evt_phy_init | input | 1 | One-cycle PHY-link initialized event |
| evt_link_on | input | 1 | One-cycle link-on active event |
| rpl_req | input | 1 | One-cycle link/PHY interface reset request |
| reg_addr | input | ADDR_W | Register word address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data |
| lps_out | output | 1 | Link-power-status line toward the PHY |
| irq | output | 1 | Interrupt request |
| pwr_down | output | 1 | Link is in power-down mode |
| regs_access_en | output | 1 | Other link registers are accessible |

## Verification
The bench builds the block with LPS_DIV=2, RST_HOLD=3, ADDR_W=4 and control address 5. These small values make every toggle period and hold window a handful of cycles, so the bench can count them exactly. With only four flags, the bench can sweep every enable mask against every single flag (64 cases) and every write-1-to-clear mask (16 cases) within a short run. The pin-versus-software ordering, the set-beats-clear collision and the synchronizer latency are each driven at a chosen cycle.

// File: rtl/lnkpwr_pkg.sv
`timescale 1ns/1ps
package lnkpwr_pkg;
    localparam int unsigned NEV       = 4;
    localparam int unsigned BIT_SWPD  = 31;
    localparam int unsigned BIT_LPST  = 30;
    localparam int unsigned BIT_EN_LO = 16;
    localparam int unsigned BIT_FL_LO = 0;

    // event indices: the position decides both flag and enable bit
    localparam int unsigned EV_SCI = 0;
    localparam int unsigned EV_SCA = 1;
    localparam int unsigned EV_LOA = 2;
    localparam int unsigned EV_PLI = 3;

    localparam logic [31:0] USED_MASK =
        (32'h1 << BIT_SWPD) | (32'((1 << NEV) - 1) << BIT_EN_LO) |
        (32'((1 << NEV) - 1) << BIT_FL_LO);

    typedef struct packed {
        logic           swpd;
        logic [NEV-1:0] en;
    } ctrl_t;

    function automatic logic [31:0] pack_rd(ctrl_t c, logic act, logic [NEV-1:0] fl);
        logic [31:0] r;
        r = '0;
        r[BIT_SWPD]          = c.swpd;
        r[BIT_LPST]          = act;
        r[BIT_EN_LO +: NEV]  = c.en;
        r[BIT_FL_LO +: NEV]  = fl;
        return r;
    endfunction
endpackage

// File: rtl/lnkpwr_sync.sv
`timescale 1ns/1ps
module lnkpwr_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-1:0], din};
    end

    assign rise = sh[STAGES-1] & ~sh[STAGES];
    assign fall = ~sh[STAGES-1] & sh[STAGES];
endmodule

// File: rtl/lnkpwr_lps.sv
`timescale 1ns/1ps
module lnkpwr_lps #(
    parameter int unsigned LPS_DIV  = 4,
    parameter int unsigned RST_HOLD = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_down,
    input  logic rpl_req,
    output logic lps_out,
    output logic active
);
    localparam int unsigned HW = $clog2(RST_HOLD + 1);
    localparam int unsigned DW = (LPS_DIV > 2) ? $clog2(LPS_DIV) : 1;

    logic [HW-1:0] hold_cnt;
    logic [DW-1:0] div_cnt;

    always_ff @(posedge clk) begin
        if (rst || rpl_req)      hold_cnt <= HW'(RST_HOLD);
        else if (hold_cnt != '0) hold_cnt <= hold_cnt - 1'b1;
    end

    assign active = !pwr_down && (hold_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            div_cnt <= '0;
            lps_out <= 1'b0;
        end else if (div_cnt == DW'(LPS_DIV - 1)) begin
            div_cnt <= '0;
            lps_out <= ~lps_out;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    // R2: an inactive line is driven low on the next edge
    assert_lps_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !active |=> !lps_out) else $error("lps toggled while inactive");

    // R6: an interface reset request drops the line
    assert_rpl_drop_R6: assert property (@(posedge clk) disable iff (rst)
        rpl_req |=> !active) else $error("rpl_req did not drop status");
endmodule

// File: rtl/lnkpwr_evt.sv
`timescale 1ns/1ps
module lnkpwr_evt #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] en,
    output logic [N-1:0] flags,
    output logic         irq
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)         flags[i] <= 1'b0;
            else if (set[i]) flags[i] <= 1'b1;
            else if (clr[i]) flags[i] <= 1'b0;
        end

        // R9: set beats clear, and a flag holds until cleared
        assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
            set[i] |=> flags[i]) else $error("flag not set");
        assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
            flags[i] && !clr[i] |=> flags[i]) else $error("flag dropped");
    end

    assign irq = |(flags & en);
endmodule

// File: rtl/lnkpwr_ctrl.sv
`timescale 1ns/1ps
module lnkpwr_ctrl
    import lnkpwr_pkg::*;
#(
    parameter int unsigned          LPS_DIV   = 4,
    parameter int unsigned          RST_HOLD  = 8,
    parameter int unsigned          ADDR_W    = 8,
    parameter logic [ADDR_W-1:0]    CTRL_ADDR = ADDR_W'(8'h40)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pd_pin,
    input  logic              phy_clk_present,
    input  logic              evt_phy_init,
    input  logic              evt_link_on,
    input  logic              rpl_req,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              lps_out,
    output logic              irq,
    output logic              pwr_down,
    output logic              regs_access_en
);
    ctrl_t          ctrl;
    logic           hit, wr_hit, act;
    logic           clk_rise, clk_fall;
    logic [NEV-1:0] ev_set, ev_clr, flags;
    logic           unused_wbits;

    assign hit    = (reg_addr == CTRL_ADDR);
    assign wr_hit = reg_wr && hit;
    assign unused_wbits = ^(reg_wdata & ~USED_MASK);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else begin
            if (pd_pin)      ctrl.swpd <= 1'b1;
            else if (wr_hit) ctrl.swpd <= reg_wdata[BIT_SWPD];
            if (wr_hit)      ctrl.en   <= reg_wdata[BIT_EN_LO +: NEV];
        end
    end

    assign pwr_down       = ctrl.swpd;
    assign regs_access_en = !ctrl.swpd;

    lnkpwr_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .din(phy_clk_present),
        .rise(clk_rise), .fall(clk_fall)
    );

    lnkpwr_lps #(.LPS_DIV(LPS_DIV), .RST_HOLD(RST_HOLD)) u_lps (
        .clk(clk), .rst(rst), .pwr_down(ctrl.swpd), .rpl_req(rpl_req),
        .lps_out(lps_out), .active(act)
    );

    always_comb begin
        ev_set         = '0;
        ev_set[EV_PLI] = evt_phy_init;
        ev_set[EV_LOA] = evt_link_on;
        ev_set[EV_SCA] = clk_rise;
        ev_set[EV_SCI] = clk_fall;
        ev_clr         = wr_hit ? reg_wdata[BIT_FL_LO +: NEV] : '0;
    end

    lnkpwr_evt #(.N(NEV)) u_evt (
        .clk(clk), .rst(rst), .set(ev_set), .clr(ev_clr), .en(ctrl.en),
        .flags(flags), .irq(irq)
    );

    assign reg_rdata = hit ? pack_rd(ctrl, act, flags) : '0;

    // R3: the pin forces power-down regardless of software
    assert_pin_forces_R3: assert property (@(posedge clk) disable iff (rst)
        pd_pin |=> pwr_down) else $error("pin did not force power-down");

    // R4: other registers close while the pin holds the link down
    assert_access_gated_R4: assert property (@(posedge clk) disable iff (rst)
        pd_pin |=> !regs_access_en) else $error("access open in power-down");
endmodule

// File: tb/sim_lnkpwr_ctrl.sv
`timescale 1ns/1ps
module sim_lnkpwr_ctrl;
    localparam logic [3:0] CA = 4'h5;

    logic        clk = 1'b0, rst = 1'b1;
    logic        pd_pin = 0, phy_clk_present = 0, evt_phy_init = 0, evt_link_on = 0, rpl_req = 0;
    logic [3:0]  reg_addr = CA;
    logic        reg_wr = 0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        lps_out, irq, pwr_down, regs_access_en;
    int          checks = 0, errors = 0;

    lnkpwr_ctrl #(.LPS_DIV(2), .RST_HOLD(3), .ADDR_W(4), .CTRL_ADDR(CA)) u0 (
        .clk(clk), .rst(rst), .pd_pin(pd_pin), .phy_clk_present(phy_clk_present),
        .evt_phy_init(evt_phy_init), .evt_link_on(evt_link_on), .rpl_req(rpl_req),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .lps_out(lps_out), .irq(irq), .pwr_down(pwr_down), .regs_access_en(regs_access_en)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = CA;
    endtask

    task automatic chk_rd(input string req, input logic [31:0] exp);
        reg_addr = CA;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic pulse_pli();
        evt_phy_init = 1'b1; @(negedge clk); evt_phy_init = 1'b0;
    endtask

    task automatic pulse_loa();
        evt_link_on = 1'b1; @(negedge clk); evt_link_on = 1'b0;
    endtask

    task automatic clk_edges();
        phy_clk_present = 1'b1; step(4);
        phy_clk_present = 1'b0; step(4);
    endtask

    task automatic count_toggles(input int n, output int cnt);
        logic prev;
        cnt = 0;
        prev = lps_out;
        for (int i = 0; i < n; i++) begin
            step(1);
            if (lps_out !== prev) cnt++;
            prev = lps_out;
        end
    endtask

    task automatic finish_up();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1 actual=hung expected=done");
        finish_up();
    end

    initial begin
        int cnt;
        step(3);
        rst = 1'b0;
        // R1 reset state
        chk_rd("R1 reset word", 32'h0);
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 lps", {31'b0, lps_out}, 0);
        chk("R1 access", {31'b0, regs_access_en}, 1);
        step(2);
        chk_rd("R1 hold window", 32'h0);
        step(1);
        // R5 active status and toggle rate
        chk_rd("R5 status active", 32'h4000_0000);
        count_toggles(8, cnt);
        chk("R5 toggle count", cnt, 4);

        // R2 software power-down
        wr(CA, 32'h8000_0000);
        chk_rd("R2 swpd word", 32'h8000_0000);
        step(1);
        chk("R2 lps low", {31'b0, lps_out}, 0);
        chk("R4 access closed", {31'b0, regs_access_en}, 0);
        count_toggles(6, cnt);
        chk("R2 no toggles", cnt, 0);
        wr(CA, 32'h0);
        chk_rd("R2 resume", 32'h4000_0000);
        chk("R4 access open", {31'b0, regs_access_en}, 1);
        count_toggles(8, cnt);
        chk("R5 toggle after resume", cnt, 4);

        // R3 pin precedence
        pd_pin = 1'b1; step(1);
        chk_rd("R3 pin forces", 32'h8000_0000);
        chk("R4 pin closes access", {31'b0, regs_access_en}, 0);
        wr(CA, 32'h0);
        chk_rd("R3 sw clear ignored", 32'h8000_0000);
        chk("R3 pwr_down held", {31'b0, pwr_down}, 1);
        pd_pin = 1'b0; step(1);
        chk_rd("R3 bit stays after pin", 32'h8000_0000);
        wr(CA, 32'h0);
        chk_rd("R3 sw clear after pin", 32'h4000_0000);

        // R6 interface reset request
        rpl_req = 1'b1; step(1); rpl_req = 1'b0;
        chk_rd("R6 drop", 32'h0);
        step(1);
        chk("R6 lps low", {31'b0, lps_out}, 0);
        step(1);
        chk_rd("R6 still held", 32'h0);
        step(1);
        chk_rd("R6 back", 32'h4000_0000);

        // R8 synchronized clock edges
        phy_clk_present = 1'b1; step(2);
        chk_rd("R8 not yet", 32'h4000_0000);
        step(1);
        chk_rd("R8 rise", 32'h4000_0002);
        phy_clk_present = 1'b0; step(3);
        chk_rd("R8 fall", 32'h4000_0003);
        chk("R7 status only irq", {31'b0, irq}, 0);
        pulse_pli(); pulse_loa();
        chk_rd("R7 all flags", 32'h4000_000F);
        chk("R7 status only irq all", {31'b0, irq}, 0);

        // R7 sweep: each flag against every enable mask
        for (int f = 0; f < 4; f++) begin
            for (int m = 0; m < 16; m++) begin
                wr(CA, 32'h0000_000F);
                if (f == 3) pulse_pli();
                else if (f == 2) pulse_loa();
                else clk_edges();
                wr(CA, (32'(m) << 16) | (32'(~(4'b1 << f)) & 32'hF));
                chk_rd("R7 enable sweep word", 32'h4000_0000 | (32'(m) << 16) | (32'h1 << f));
                chk("R7 irq", {31'b0, irq}, {31'b0, m[f]});
            end
        end

        // R9 write-1-to-clear sweep
        for (int m = 0; m < 16; m++) begin
            pulse_pli(); pulse_loa(); clk_edges();
            wr(CA, 32'h000F_0000 | 32'(m));
            chk_rd("R9 w1c word", 32'h400F_0000 | (32'(~m) & 32'hF));
            chk("R9 irq", {31'b0, irq}, {31'b0, ((~m) & 15) != 0});
        end

        // R9 set beats clear
        wr(CA, 32'h0000_000F);
        reg_addr = CA; reg_wdata = 32'h0000_0008; reg_wr = 1'b1; evt_phy_init = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; evt_phy_init = 1'b0;
        chk_rd("R9 set wins", 32'h4000_0008);

        // R10 unused bits and other addresses
        wr(CA, 32'h3FF0_FFF8);
        chk_rd("R10 unused bits", 32'h4000_0000);
        reg_addr = CA ^ 4'h1; #1;
        chk("R10 other addr read", reg_rdata, 32'h0);
        wr(CA ^ 4'h1, 32'h800F_0000);
        chk("R10 other addr write", {31'b0, pwr_down}, 0);
        chk_rd("R10 word unchanged", 32'h4000_0000);

        finish_up();
    end
endmodule